// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This controller sits on the programmer side of a word-wide UV-erasable memory and writes a complete image into it. A start command puts the supply selector at the programming level and switches margin mode on. Then it programs the addresses in ascending order. For each address it fetches the target word from an image source, drives address and data, and raises the programming supply. It applies one fixed-width chip-enable pulse and then reads the word back with the data bus released. A mismatch earns another pulse. A match moves on at once, with no extra pulse.

A word that still reads wrong after the pulse cap is reached aborts the run. After the last address, margin mode is switched off and the whole array is read back twice: first with the supply selector at the high check level, then at the low check level. Any mismatch in either pass is a failure. All durations (pulse width, setup and hold, read sampling delay) are parameters in clock cycles. The supply levels themselves are produced outside the block from a 2-bit selector.

Top module: `eprom_prog_ctrl`

## Requirements
- R1: After reset the controller is idle. Chip enable and output enable are high (inactive), the programming supply and margin mode are off, the supply selector reads 0 (nominal), and busy, done and fail are low.
- R2: From start until the last address passes verify, the selector reads 1 (programming level) during every program pulse, and margin mode is on. Margin mode is off at every read of the final check.
- R3: Before each program pulse, address, data, data-bus drive and programming supply stay unchanged for at least SETUP_CYC cycles before chip enable falls.
- R4: Each program pulse holds chip enable low for exactly PULSE_CYC cycles.
- R5: After each pulse the word is read back with chip enable and output enable low, the programming supply off and the data bus not driven. A matching read advances to the next address with no further pulse. The number of pulses a word receives therefore equals the number it needs, and the finished array equals the image.
- R6: A word gets at most MAX_PULSES pulses. If it still mismatches after the last of them, the run ends with done and fail high and fail_addr set to that address, and no later address is pulsed.
- R7: After programming, every word is read in ascending address order with the selector at 2 (high check level), then again in ascending order at 3 (low check level). The first mismatch ends the run with fail high and fail_addr set to that address.
- R8: Done and fail stay set until the next start, which clears both. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a programming run (accepted when idle) |
| src_req_o | output | 1 | Image word request |
| src_addr_o | output | ADDR_W | Address of the requested image word |
| src_vld_i | input | 1 | Image word valid |
| src_data_i | input | DATA_W | Image word |
| dev_addr_o | output | ADDR_W | Memory address lines |
| dev_data_o | output | DATA_W | Data driven toward the memory |
| dev_data_oe_o | output | 1 | Programmer drives the data bus |
| dev_data_i | input | DATA_W | Data read from the memory |
| dev_ce_n_o | output | 1 | Chip enable, active low |
| dev_oe_n_o | output | 1 | Output enable, active low |
| vpp_hi_o | output | 1 | Programming supply raised |
| margin_o | output | 1 | Margin mode on |
| vcc_sel_o | output | 2 | Supply level: 0 nominal, 1 program, 2 high check, 3 low check |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (sticky) |
| fail_o | output | 1 | Run failed (sticky) |
| fail_addr_o | output | ADDR_W | Address of the failing word |

## Verification
A stuck or skipped sequencer state shows at the device pins within one phase. A dropped setup phase shortens the stable window before chip enable falls. A miscounted timer changes the measured low time of the very next pulse. A wrong retry count shows as a pulse total per word that differs from the bench's computed need. An off-by-one at the cap shows either as a 26th pulse or as a false failure on a word needing exactly 25. A margin or supply-select error appears at the first pulse or the first check read. A check-phase slip shows in the logged read order, and a bad sticky flag shows in the cycles after the run ends.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_SETUP, ST_PULSE, ST_HOLD, ST_VERIFY, ST_MCLR, ST_CREAD
  } state_e;

  typedef enum logic [1:0] {
    VCC_NOM  = 2'd0,
    VCC_PROG = 2'd1,
    VCC_HI   = 2'd2,
    VCC_LO   = 2'd3
  } vcc_e;
endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  // load with len-1 so the phase lasts exactly len cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/attempt_counter.sv
module attempt_counter #(
  parameter int MAX = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int W = $clog2(MAX + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (clr_i)                                cnt_q <= '0;
    else if (inc_i && cnt_q != W'(MAX - 1))        cnt_q <= cnt_q + W'(1);
  end

  // true while the pulse just verified is the MAX-th one
  assign last_o = (cnt_q == W'(MAX - 1));
endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_prog_pkg::*;
#(
  parameter int NUM_WORDS  = 2097152,
  parameter int DATA_W     = 16,
  parameter int PULSE_CYC  = 2500,
  parameter int SETUP_CYC  = 50,
  parameter int SAMPLE_CYC = 50,
  parameter int MAX_PULSES = 25,
  localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              src_req_o,
  output logic [ADDR_W-1:0] src_addr_o,
  input  logic              src_vld_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [DATA_W-1:0] dev_data_o,
  output logic              dev_data_oe_o,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic              dev_ce_n_o,
  output logic              dev_oe_n_o,
  output logic              vpp_hi_o,
  output logic              margin_o,
  output logic [1:0]        vcc_sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o
);
  localparam int MAX_AB = (PULSE_CYC > SETUP_CYC) ? PULSE_CYC : SETUP_CYC;
  localparam int MAX_C  = (MAX_AB > SAMPLE_CYC) ? MAX_AB : SAMPLE_CYC;
  localparam int TW     = $clog2(MAX_C + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

  state_e            state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d, fail_addr_q, fail_addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              check_q, check_d, pass_q, pass_d, margin_q, margin_d;
  logic              done_q, done_d, fail_q, fail_d;

  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_len;
  logic              cnt_clr, cnt_inc, cnt_last;
  logic              match, at_last;

  prog_timer #(.W(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .len_i(tmr_len), .zero_o(tmr_zero)
  );

  attempt_counter #(.MAX(MAX_PULSES)) u_attempts (
    .clk_i, .rst_ni, .clr_i(cnt_clr), .inc_i(cnt_inc), .last_o(cnt_last)
  );

  assign match   = (dev_data_i == wdata_q);
  assign at_last = (addr_q == LAST_ADDR);

  always_comb begin
    state_d     = state_q;
    addr_d      = addr_q;
    wdata_d     = wdata_q;
    check_d     = check_q;
    pass_d      = pass_q;
    margin_d    = margin_q;
    done_d      = done_q;
    fail_d      = fail_q;
    fail_addr_d = fail_addr_q;
    tmr_load    = 1'b0;
    tmr_len     = TW'(SETUP_CYC);
    cnt_clr     = 1'b0;
    cnt_inc     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        addr_d      = '0;
        check_d     = 1'b0;
        pass_d      = 1'b0;
        margin_d    = 1'b1;
        done_d      = 1'b0;
        fail_d      = 1'b0;
        fail_addr_d = '0;
        state_d     = ST_FETCH;
      end
      ST_FETCH: if (src_vld_i) begin
        wdata_d  = src_data_i;
        tmr_load = 1'b1;
        if (check_q) begin
          tmr_len = TW'(SAMPLE_CYC);
          state_d = ST_CREAD;
        end else begin
          cnt_clr = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_len  = TW'(PULSE_CYC);
        state_d  = ST_PULSE;
      end
      ST_PULSE: if (tmr_zero) begin
        tmr_load = 1'b1;
        state_d  = ST_HOLD;
      end
      ST_HOLD: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_len  = TW'(SAMPLE_CYC);
        state_d  = ST_VERIFY;
      end
      ST_VERIFY: if (tmr_zero) begin
        if (match) begin
          if (at_last) begin
            margin_d = 1'b0;
            tmr_load = 1'b1;
            state_d  = ST_MCLR;
          end else begin
            addr_d  = addr_q + ADDR_W'(1);
            state_d = ST_FETCH;
          end
        end else if (cnt_last) begin
          margin_d    = 1'b0;
          done_d      = 1'b1;
          fail_d      = 1'b1;
          fail_addr_d = addr_q;
          state_d     = ST_IDLE;
        end else begin
          cnt_inc  = 1'b1;
          tmr_load = 1'b1;
          state_d  = ST_SETUP;
        end
      end
      ST_MCLR: if (tmr_zero) begin
        check_d = 1'b1;
        pass_d  = 1'b0;
        addr_d  = '0;
        state_d = ST_FETCH;
      end
      ST_CREAD: if (tmr_zero) begin
        if (!match) begin
          done_d      = 1'b1;
          fail_d      = 1'b1;
          fail_addr_d = addr_q;
          check_d     = 1'b0;
          state_d     = ST_IDLE;
        end else if (!at_last) begin
          addr_d  = addr_q + ADDR_W'(1);
          state_d = ST_FETCH;
        end else if (!pass_q) begin
          pass_d  = 1'b1;
          addr_d  = '0;
          state_d = ST_FETCH;
        end else begin
          done_d  = 1'b1;
          check_d = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      check_q     <= 1'b0;
      pass_q      <= 1'b0;
      margin_q    <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      state_q     <= state_d;
      addr_q      <= addr_d;
      wdata_q     <= wdata_d;
      check_q     <= check_d;
      pass_q      <= pass_d;
      margin_q    <= margin_d;
      done_q      <= done_d;
      fail_q      <= fail_d;
      fail_addr_q <= fail_addr_d;
    end
  end

  logic prog_win;
  assign prog_win = (state_q == ST_SETUP) || (state_q == ST_PULSE) || (state_q == ST_HOLD);

  assign src_req_o     = (state_q == ST_FETCH);
  assign src_addr_o    = addr_q;
  assign dev_addr_o    = addr_q;
  assign dev_data_o    = wdata_q;
  assign dev_data_oe_o = prog_win;
  assign vpp_hi_o      = prog_win;
  assign dev_ce_n_o    = !((state_q == ST_PULSE) || (state_q == ST_VERIFY) || (state_q == ST_CREAD));
  assign dev_oe_n_o    = !((state_q == ST_VERIFY) || (state_q == ST_CREAD));
  assign margin_o      = margin_q;
  assign vcc_sel_o     = (state_q == ST_IDLE) ? VCC_NOM :
                         !check_q ? VCC_PROG : (pass_q ? VCC_LO : VCC_HI);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign fail_o        = fail_q;
  assign fail_addr_o   = fail_addr_q;
endmodule

// File: rtl/eprom_prog_ctrl_chk.sv
module eprom_prog_ctrl_chk #(
  parameter int PULSE_CYC  = 5,
  parameter int MAX_PULSES = 25,
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              src_req_o,
  input logic [ADDR_W-1:0] dev_addr_o,
  input logic [DATA_W-1:0] dev_data_o,
  input logic              dev_data_oe_o,
  input logic              dev_ce_n_o,
  input logic              dev_oe_n_o,
  input logic              vpp_hi_o,
  input logic              margin_o,
  input logic [1:0]        vcc_sel_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o
);
  logic [31:0] low_cnt, pulse_cnt;
  logic        ce_n_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt   <= '0;
      pulse_cnt <= '0;
      ce_n_d    <= 1'b1;
    end else begin
      ce_n_d  <= dev_ce_n_o;
      low_cnt <= (!dev_ce_n_o && vpp_hi_o) ? low_cnt + 32'd1 : 32'd0;
      if (src_req_o)                            pulse_cnt <= '0;
      else if (ce_n_d && !dev_ce_n_o && vpp_hi_o) pulse_cnt <= pulse_cnt + 32'd1;
    end
  end

  a_r2_prog_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dev_ce_n_o && vpp_hi_o) |-> (vcc_sel_o == 2'd1 && margin_o));

  a_r2_margin_off_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_sel_o[1]) |-> !margin_o);

  a_r3_setup_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dev_ce_n_o) && vpp_hi_o) |->
      ($stable(dev_addr_o) && $stable(dev_data_o) && $past(vpp_hi_o) && $past(dev_data_oe_o)));

  a_r4_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dev_ce_n_o) && $past(vpp_hi_o)) |-> (low_cnt == 32'(PULSE_CYC)));

  a_r5_bus_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dev_oe_n_o |-> (!dev_data_oe_o && !vpp_hi_o && !dev_ce_n_o));

  a_r6_retry_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt <= 32'(MAX_PULSES));

  a_r6_fail_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (done_o && (!busy_o || $past(start_i))));

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r8_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_i) |=> fail_o);
endmodule

bind eprom_prog_ctrl eprom_prog_ctrl_chk #(
  .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .src_req_o(src_req_o),
  .dev_addr_o(dev_addr_o), .dev_data_o(dev_data_o), .dev_data_oe_o(dev_data_oe_o),
  .dev_ce_n_o(dev_ce_n_o), .dev_oe_n_o(dev_oe_n_o), .vpp_hi_o(vpp_hi_o),
  .margin_o(margin_o), .vcc_sel_o(vcc_sel_o), .busy_o(busy_o), .done_o(done_o),
  .fail_o(fail_o)
);

// File: tb/sim_eprom_prog_ctrl.sv
`timescale 1ns/1ps
module sim_eprom_prog_ctrl;
  localparam int NW = 8;
  localparam int PC = 5;
  localparam int SC = 3;
  localparam int RC = 2;
  localparam int MP = 25;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0;
  logic          src_req, src_vld = 1'b0;
  logic [AW-1:0] src_addr, dev_addr, fail_addr;
  logic [15:0]   src_data = '0, dev_wdata, dev_rdata;
  logic          data_oe, ce_n, oe_n, vpp, margin, busy, done, fail;
  logic [1:0]    vcc;

  eprom_prog_ctrl #(
    .NUM_WORDS(NW), .DATA_W(16), .PULSE_CYC(PC), .SETUP_CYC(SC),
    .SAMPLE_CYC(RC), .MAX_PULSES(MP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_req_o(src_req), .src_addr_o(src_addr), .src_vld_i(src_vld), .src_data_i(src_data),
    .dev_addr_o(dev_addr), .dev_data_o(dev_wdata), .dev_data_oe_o(data_oe),
    .dev_data_i(dev_rdata), .dev_ce_n_o(ce_n), .dev_oe_n_o(oe_n), .vpp_hi_o(vpp),
    .margin_o(margin), .vcc_sel_o(vcc), .busy_o(busy), .done_o(done), .fail_o(fail),
    .fail_addr_o(fail_addr)
  );

  int checks = 0, errors = 0, run_id = 0;
  logic [15:0] mem [NW];
  int pulses [NW];
  int rd_n;
  logic [AW-1:0] rd_addr [2*NW];
  logic [1:0]    rd_vcc  [2*NW];

  function automatic logic [15:0] img(int a);
    return 16'(a * 16'h1357) ^ 16'hA5C3;
  endfunction

  function automatic int need(int r, int a);
    if (r == 1 && a == 5) return MP + 1;
    if (a == NW - 1) return MP;
    return (a % 4) + 1;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: reads only with ce and oe low; run 2 corrupts one word at the low check level
  always_comb begin
    if (!ce_n && !oe_n)
      dev_rdata = (run_id == 2 && vcc == 2'd3 && dev_addr == 3'd2) ? (mem[dev_addr] ^ 16'h0001)
                                                                   : mem[dev_addr];
    else
      dev_rdata = '0;
  end

  always @(negedge clk) begin
    src_vld  <= src_req;
    src_data <= img(int'(src_addr));
  end

  logic [AW-1:0] p_addr = '0;
  logic [15:0]   p_data = '0;
  logic          p_vpp = 1'b0, p_oe = 1'b0, p_ce = 1'b1, p_oen = 1'b1, p_busy = 1'b0;
  int stab = 0, low = 0;

  always @(negedge clk) begin
    if (start && !p_busy) begin
      for (int a = 0; a < NW; a++) begin
        mem[a] = 16'hFFFF;
        pulses[a] = 0;
      end
      rd_n = 0;
    end
    if (rst_n) begin
      if (dev_addr != p_addr || dev_wdata != p_data || vpp != p_vpp || data_oe != p_oe) stab = 0;
      else stab++;
      if (p_ce && !ce_n && vpp) begin
        chk(stab >= SC, "R3 setup window", stab, SC);
        chk(vcc == 2'd1 && margin, "R2 level/margin at pulse", {vcc, margin}, 3'b011);
        pulses[dev_addr]++;
        if (pulses[dev_addr] >= need(run_id, int'(dev_addr)))
          mem[dev_addr] = mem[dev_addr] & dev_wdata;
      end
      if (!p_ce && ce_n && p_vpp) chk(low == PC, "R4 pulse width", low, PC);
      low = (!ce_n && vpp) ? low + 1 : 0;
      if (p_oen && !oe_n)
        chk(!data_oe && !vpp && !ce_n, "R5 read bus state", {data_oe, vpp, ce_n}, 3'b000);
      if (p_ce && !ce_n && !oe_n && vcc[1]) begin
        chk(!margin, "R2 margin off in check", margin, 0);
        if (rd_n < 2 * NW) begin
          rd_addr[rd_n] = dev_addr;
          rd_vcc[rd_n]  = vcc;
        end
        rd_n++;
      end
    end
    p_addr = dev_addr; p_data = dev_wdata; p_vpp = vpp; p_oe = data_oe;
    p_ce = ce_n; p_oen = oe_n; p_busy = busy;
  end

  task automatic do_run(int r, bit restart_mid);
    run_id = r;
    @(negedge clk); #2 start = 1'b1;
    @(negedge clk); #2 start = 1'b0;
    chk(!done && !fail && busy, "R8 start clears flags", {done, fail, busy}, 3'b001);
    if (restart_mid) begin
      repeat (40) @(negedge clk);
      #2 start = 1'b1;
      @(negedge clk); #2 start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && !vpp && !margin && vcc == 2'd0 && !busy && !done && !fail,
        "R1 reset state", {ce_n, oe_n, vpp, margin, vcc, busy, done, fail}, 8'hC0);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && !busy && !done, "R1 idle after release", {ce_n, busy, done}, 3'b100);

    // run 0: clean image, last word needs exactly the cap, start pulsed mid-run
    do_run(0, 1'b1);
    chk(done && !fail && !busy, "R7 run0 passes", {done, fail, busy}, 3'b100);
    chk(ce_n && oe_n && !vpp && !margin && vcc == 2'd0, "R1 idle pins after run",
        {ce_n, oe_n, vpp, margin, vcc}, 6'b110000);
    for (int a = 0; a < NW; a++) begin
      chk(pulses[a] == need(0, a), "R5 pulses per word (R8 restart ignored)", pulses[a], need(0, a));
      chk(mem[a] == img(a), "R5 programmed word", mem[a], img(a));
    end
    chk(rd_n == 2 * NW, "R7 check read count", rd_n, 2 * NW);
    for (int i = 0; i < 2 * NW && i < rd_n; i++) begin
      chk(int'(rd_addr[i]) == (i % NW), "R7 check order", rd_addr[i], i % NW);
      chk(rd_vcc[i] == ((i < NW) ? 2'd2 : 2'd3), "R7 check level", rd_vcc[i], (i < NW) ? 2 : 3);
    end
    repeat (20) @(negedge clk);
    chk(done && !fail, "R8 done sticky", {done, fail}, 2'b10);

    // run 1: word 5 needs one pulse beyond the cap
    do_run(1, 1'b0);
    chk(done && fail && !busy, "R6 fail flags", {done, fail, busy}, 3'b110);
    chk(fail_addr == 3'd5, "R6 fail address", fail_addr, 5);
    chk(pulses[5] == MP, "R6 pulse cap", pulses[5], MP);
    chk(pulses[6] == 0 && pulses[7] == 0, "R6 no later pulses", pulses[6] + pulses[7], 0);
    chk(rd_n == 0, "R6 no check after fail", rd_n, 0);
    chk(!margin && vcc == 2'd0, "R6 idle supply after fail", {margin, vcc}, 0);
    repeat (10) @(negedge clk);
    chk(fail && done, "R8 fail sticky", {done, fail}, 2'b11);

    // run 2: word 2 reads wrong only at the low check level
    do_run(2, 1'b0);
    chk(done && fail, "R7 low-level check fails", {done, fail}, 2'b11);
    chk(fail_addr == 3'd2, "R7 check fail address", fail_addr, 2);
    chk(rd_n == NW + 3, "R7 reads up to failure", rd_n, NW + 3);
    for (int a = 0; a < NW; a++)
      chk(mem[a] == img(a), "R5 image in run2", mem[a], img(a));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule